// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single timer channel built around a down counter (16 bits by default). A host-side bus block, which is not part of this design, hands the channel a mode code and a binary/BCD select through a control strobe, and an initial count through a load strobe. The channel then drives its OUT pin according to one of six waveforms: an interrupt on terminal count, a one-shot started by GATE that GATE can restart, a rate generator, a square wave, a strobe started by software, and a strobe started by GATE.

The live count and a flag marking a written count that has not yet been transferred into the counter are brought out. The bus block reads them back from there. Depending on the mode, GATE acts either as a level enable or as a rising-edge trigger. The count runs in plain binary or in four-digit packed BCD.

Top module: `pit_channel`

## Requirements
- R1: After reset, OUT is high, the live count is 0 and the null-count flag is clear.
- R2: Mode code 0 (terminal count). A control write drives OUT low on the next clock. The clock after a count write loads the counter and holds OUT low. OUT rises on the clock where the count steps from 1 to 0. It stays high until the next count or control write.
- R3: Mode code 1 (one-shot). A GATE rising edge loads the most recently written count and drives OUT low. OUT rises when the count steps from 1 to 0. A count written during a pulse leaves that pulse unchanged. A GATE rising edge during a pulse restarts it with the latest count.
- R4: Mode code 2 (rate). OUT is low only while the live count equals 1. On the next clock the counter reloads, so the period is N clocks for a count N of 2 or more. A count written while running takes effect at the next reload.
- R5: Mode code 3 (square). The counter steps N down to 1 and then reloads. OUT is high while the live count is above floor(N/2), so it is high for (N+1)/2 clocks and low for N/2 clocks, rounded down. N must be 2 or more.
- R6: Mode code 4 (software strobe). The clock after a count write loads the counter, with OUT high. OUT is low for exactly one clock as the count steps from 1 to 0. There is no reload.
- R7: Mode code 5 (GATE strobe). This is the same as R6, except that a GATE rising edge starts the load. A further rising edge restarts the count.
- R8: Each count step subtracts one. In BCD mode the step works digit by digit: 0000 goes to 9999 and 0010 goes to 0009. A written count of 0 gives 65536 clocks in binary and 10000 clocks in BCD.
- R9: The null-count flag is set on the clock after a count write or a control write. It clears on the clock after the written count moves into the counter.
- R10: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R11: In modes 0, 2 and 3, a low GATE holds the count. In modes 2 and 3, a low GATE also forces OUT high, and a GATE rising edge reloads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | GATE level/edge input |
| ctl_wr | input | 1 | Control strobe |
| ctl_mode | input | 3 | Mode code 0..7 |
| ctl_bcd | input | 1 | 1 selects BCD counting |
| ld_wr | input | 1 | Count load strobe |
| ld_val | input | W | Initial count (packed BCD when BCD is selected) |
| out | output | 1 | OUT waveform |
| count | output | W | Live counter value |
| null_count | output | 1 | Written count not yet in the counter |

## Verification
A wrong count register, or a BCD borrow that goes astray, shows up on `count` in the very clock it happens. It reaches OUT at the next terminal count or square-wave midpoint, so within one period. A stuck running flag or a wrong pending-load flag shows up as a missing or extra reload. OUT then goes wrong at the next expiry, and `null_count` fails to clear one clock after the expected transfer. GATE handling faults appear at the first clock after a GATE edge, as a count that does not hold or does not restart.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_TC      = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3,
    MODE_SWSTB   = 3'd4,
    MODE_HWSTB   = 3'd5
  } pit_mode_e;

  // Codes 6 and 7 fold onto the periodic modes.
  function automatic pit_mode_e pit_decode_mode(input logic [2:0] code);
    pit_mode_e m;
    case (code)
      3'd0:    m = MODE_TC;
      3'd1:    m = MODE_ONESHOT;
      3'd2:    m = MODE_RATE;
      3'd3:    m = MODE_SQUARE;
      3'd4:    m = MODE_SWSTB;
      3'd5:    m = MODE_HWSTB;
      3'd6:    m = MODE_RATE;
      default: m = MODE_SQUARE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pit_cnt_dec.sv
module pit_cnt_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         bcd,
  output logic [W-1:0] nxt
);
  localparam int ND = W / 4;

  logic [ND-1:0] borrow;
  logic [W-1:0]  bcd_nxt;

  assign borrow[0] = 1'b1;

  generate
    for (genvar i = 0; i < ND; i++) begin : g_dig
      assign bcd_nxt[4*i +: 4] = !borrow[i] ? cur[4*i +: 4] :
                                 (cur[4*i +: 4] == 4'd0) ? 4'd9 : cur[4*i +: 4] - 4'd1;
      if (i < ND - 1) begin : g_chain
        assign borrow[i+1] = borrow[i] & (cur[4*i +: 4] == 4'd0);
      end
    end
  endgenerate

  assign nxt = bcd ? bcd_nxt : cur - W'(1);

endmodule

// File: rtl/pit_cnt_half.sv
module pit_cnt_half #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] half
);
  localparam int ND = W / 4;
  localparam logic [W-1:0] BIN_TOP = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] BCD_TOP = {4'd5, {(W-4){1'b0}}};

  logic          is_zero;
  logic [W-1:0]  bcd_half;

  assign is_zero = ~|val;

  generate
    for (genvar i = 0; i < ND; i++) begin : g_dig
      if (i == ND - 1) begin : g_top
        assign bcd_half[4*i +: 4] = {1'b0, val[4*i+1 +: 3]};
      end else begin : g_low
        assign bcd_half[4*i +: 4] = {1'b0, val[4*i+1 +: 3]} +
                                    (val[4*(i+1)] ? 4'd5 : 4'd0);
      end
    end
  endgenerate

  always_comb begin
    if (is_zero) half = bcd ? BCD_TOP : BIN_TOP;
    else         half = bcd ? bcd_half : (val >> 1);
  end

endmodule

// File: rtl/pit_out_shape.sv
module pit_out_shape
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  pit_mode_e    mode,
  input  logic         load,
  input  logic         run_q,
  input  logic         run_n,
  input  logic         en,
  input  logic         gate,
  input  logic         cnt_one,
  input  logic [W-1:0] cnt_n,
  input  logic [W-1:0] half,
  input  logic         out_q,
  output logic         out_n
);
  logic next_is_one;
  logic next_upper;

  assign next_is_one = (cnt_n == W'(1));
  assign next_upper  = (cnt_n == '0) || (cnt_n > half);

  always_comb begin
    case (mode)
      MODE_TC: begin
        if (load)                   out_n = 1'b0;
        else if (run_q && en && cnt_one) out_n = 1'b1;
        else                        out_n = out_q;
      end
      MODE_ONESHOT: begin
        if (load)                   out_n = 1'b0;
        else if (run_q && cnt_one)  out_n = 1'b1;
        else                        out_n = out_q;
      end
      MODE_RATE:   out_n = !(run_n && gate && next_is_one);
      MODE_SQUARE: out_n = (run_n && gate) ? next_upper : 1'b1;
      default:     out_n = load ? 1'b1 : !(run_q && cnt_one);
    endcase
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         ctl_wr,
  input  logic [2:0]   ctl_mode,
  input  logic         ctl_bcd,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_val,
  output logic         out,
  output logic [W-1:0] count,
  output logic         null_count
);
  localparam logic [W-1:0] ONE = W'(1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pit_mode_e    mode_q, mode_n;
  logic         bcd_q, bcd_n;
  logic [W-1:0] init_q, init_n;
  logic [W-1:0] act_q, act_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic         out_q, out_n;
  logic         run_q, run_n;
  logic         pend_q, pend_n;
  logic         have_q, have_n;
  logic         null_q, null_n;
  logic         gate_q;

  logic         gate_rise, en, load, cnt_one, periodic;
  logic         shaped_out;
  logic [W-1:0] dec_val, half_val;
  pit_mode_e    new_mode;

  assign gate_rise = gate & ~gate_q;
  assign cnt_one   = (cnt_q == ONE);
  assign periodic  = (mode_q == MODE_RATE) || (mode_q == MODE_SQUARE);
  assign new_mode  = pit_decode_mode(ctl_mode);

  pit_cnt_dec #(.W(W)) u_dec (
    .cur (cnt_q),
    .bcd (bcd_q),
    .nxt (dec_val)
  );

  pit_cnt_half #(.W(W)) u_half (
    .val  (act_n),
    .bcd  (bcd_q),
    .half (half_val)
  );

  pit_out_shape #(.W(W)) u_shape (
    .mode    (mode_q),
    .load    (load),
    .run_q   (run_q),
    .run_n   (run_n),
    .en      (en),
    .gate    (gate),
    .cnt_one (cnt_one),
    .cnt_n   (cnt_n),
    .half    (half_val),
    .out_q   (out_q),
    .out_n   (shaped_out)
  );

  // counting enable and transfer decision
  always_comb begin
    en = (mode_q == MODE_TC || periodic) ? gate : 1'b1;
    case (mode_q)
      MODE_TC, MODE_SWSTB:      load = pend_q;
      MODE_ONESHOT, MODE_HWSTB: load = gate_rise & have_q;
      default:                  load = have_q & ((pend_q & ~run_q) | gate_rise |
                                                 (run_q & gate & cnt_one));
    endcase
  end

  // counter datapath next state
  always_comb begin
    cnt_n  = cnt_q;
    act_n  = act_q;
    run_n  = run_q;
    pend_n = pend_q;
    null_n = null_q;
    if (load) begin
      cnt_n  = init_q;
      act_n  = init_q;
      run_n  = 1'b1;
      pend_n = 1'b0;
      null_n = 1'b0;
    end else if (run_q && en) begin
      cnt_n = dec_val;
      if (cnt_one && !periodic) run_n = 1'b0;
    end
    if (ctl_wr) begin
      cnt_n  = cnt_q;
      act_n  = act_q;
      run_n  = 1'b0;
      pend_n = 1'b0;
      null_n = 1'b1;
    end
    if (ld_wr) begin
      pend_n = 1'b1;
      null_n = 1'b1;
    end
  end

  // configuration next state
  always_comb begin
    mode_n = mode_q;
    bcd_n  = bcd_q;
    init_n = init_q;
    have_n = have_q;
    out_n  = shaped_out;
    if (ctl_wr) begin
      mode_n = new_mode;
      bcd_n  = ctl_bcd;
      have_n = 1'b0;
      out_n  = (new_mode != MODE_TC);
    end
    if (ld_wr) begin
      init_n = ld_val;
      have_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MODE_TC;
      bcd_q  <= 1'b0;
      init_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      have_q <= 1'b0;
      null_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      bcd_q  <= bcd_n;
      init_q <= init_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      out_q  <= out_n;
      run_q  <= run_n;
      pend_q <= pend_n;
      have_q <= have_n;
      null_q <= null_n;
      gate_q <= gate;
    end
  end

  assign out        = out_q;
  assign count      = cnt_q;
  assign null_count = null_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_wr,
  input logic [2:0]   ctl_mode,
  input logic         ld_wr,
  input logic         out,
  input logic         null_count,
  input pit_mode_e    mode_q,
  input logic         run_q,
  input logic         bcd_q,
  input logic [W-1:0] cnt_q
);
  logic bad_digit;

  always_comb begin
    bad_digit = 1'b0;
    for (int i = 0; i < W / 4; i++)
      if (cnt_q[4*i +: 4] > 4'd9) bad_digit = 1'b1;
  end

  assert_tc_low_after_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_mode == 3'd0) |=> !out);

  assert_rate_low_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RATE && !out && !ctl_wr) |=> out);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_SWSTB || mode_q == MODE_HWSTB) && !out && !ctl_wr) |=> out);

  assert_bcd_digits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && bcd_q) |-> !bad_digit);

  assert_null_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> null_count);

endmodule

bind pit_channel pit_channel_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_mode   (ctl_mode),
  .ld_wr      (ld_wr),
  .out        (out),
  .null_count (null_count),
  .mode_q     (mode_q),
  .run_q      (run_q),
  .bcd_q      (bcd_q),
  .cnt_q      (cnt_q)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         gate;
  logic         ctl_wr;
  logic [2:0]   ctl_mode;
  logic         ctl_bcd;
  logic         ld_wr;
  logic [W-1:0] ld_val;
  logic         out;
  logic [W-1:0] count;
  logic         null_count;

  always #4 clk = ~clk;

  pit_channel #(.W(W)) u_pit_channel (
    .clk(clk), .rst_n(rst_n), .gate(gate), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .ctl_bcd(ctl_bcd), .ld_wr(ld_wr), .ld_val(ld_val), .out(out), .count(count),
    .null_count(null_count)
  );

  int vectors = 0;
  int fails   = 0;
  bit chk_on  = 0;
  bit done    = 0;

  // behavioural reference state (numeric values; 0 in count means full range)
  int m_mode, m_bcd, m_init, m_act, m_cnt, m_out, m_run, m_pend, m_have, m_null, m_gq;
  int m_alias;
  int ld_num;

  function automatic logic [15:0] enc(input int v, input int b);
    if (b != 0) return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    return v[15:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_bcd = 0; m_init = 0; m_act = 0; m_cnt = 0; m_out = 1;
      m_run = 0; m_pend = 0; m_have = 0; m_null = 0; m_gq = 0; m_alias = 0;
    end else begin
      int maxv, rise, en, ld, nc, na, nr, np, nn, nh, ni, no, nm, nb, hv;
      maxv = (m_bcd != 0) ? 10000 : 65536;
      rise = (gate && m_gq == 0) ? 1 : 0;
      en   = (m_mode == 0 || m_mode == 2 || m_mode == 3) ? int'(gate) : 1;
      if (m_mode == 0 || m_mode == 4)      ld = m_pend;
      else if (m_mode == 1 || m_mode == 5) ld = rise & m_have;
      else ld = m_have & ((m_pend & ~m_run & 1) | rise | (m_run & int'(gate) & int'(m_cnt == 1)));
      nc = m_cnt; na = m_act; nr = m_run; np = m_pend; nn = m_null; nh = m_have;
      ni = m_init; no = m_out; nm = m_mode; nb = m_bcd;
      if (ld != 0) begin
        nc = m_init; na = m_init; nr = 1; np = 0; nn = 0;
      end else if (m_run != 0 && en != 0) begin
        nc = (m_cnt == 0) ? maxv - 1 : m_cnt - 1;
        if (m_cnt == 1 && m_mode != 2 && m_mode != 3) nr = 0;
      end
      hv = ((na == 0) ? maxv : na) / 2;
      case (m_mode)
        0: no = (ld != 0) ? 0 : (m_run != 0 && en != 0 && m_cnt == 1) ? 1 : m_out;
        1: no = (ld != 0) ? 0 : (m_run != 0 && m_cnt == 1) ? 1 : m_out;
        2: no = (nr != 0 && gate && nc == 1) ? 0 : 1;
        3: no = (nr != 0 && gate) ? int'(nc == 0 || nc > hv) : 1;
        default: no = (ld != 0) ? 1 : (m_run != 0 && m_cnt == 1) ? 0 : 1;
      endcase
      if (ctl_wr) begin
        nm = (ctl_mode == 3'd6) ? 2 : (ctl_mode == 3'd7) ? 3 : int'(ctl_mode);
        m_alias = (ctl_mode >= 3'd6) ? 1 : 0;
        nb = int'(ctl_bcd); nr = 0; np = 0; nh = 0; nn = 1;
        no = (nm == 0) ? 0 : 1; nc = m_cnt; na = m_act;
      end
      if (ld_wr) begin
        ni = ld_num; np = 1; nh = 1; nn = 1;
      end
      m_cnt = nc; m_act = na; m_run = nr; m_pend = np; m_null = nn; m_have = nh;
      m_init = ni; m_out = no; m_mode = nm; m_bcd = nb; m_gq = int'(gate);
    end
  end

  function automatic string out_tag();
    if (m_gq == 0 && (m_mode == 0 || m_mode == 2 || m_mode == 3)) return "R11";
    if (m_alias != 0) return "R10";
    case (m_mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      vectors++;
      if (out !== m_out[0]) begin
        fails++;
        $display("FAIL %s out actual=%0b expected=%0d t=%0t", out_tag(), out, m_out, $time);
      end
      if (count !== enc(m_cnt, m_bcd)) begin
        fails++;
        $display("FAIL R8 count actual=%h expected=%h t=%0t", count, enc(m_cnt, m_bcd), $time);
      end
      if (null_count !== m_null[0]) begin
        fails++;
        $display("FAIL R9 null_count actual=%0b expected=%0d t=%0t", null_count, m_null, $time);
      end
    end
  end

  task automatic do_ctl(input int code, input int b);
    @(negedge clk); ctl_wr = 1'b1; ctl_mode = 3'(code); ctl_bcd = b[0];
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic do_ld(input int n);
    @(negedge clk); ld_wr = 1'b1; ld_val = enc(n, m_bcd); ld_num = n;
    @(negedge clk); ld_wr = 1'b0;
  endtask

  task automatic gate_set(input bit v);
    @(negedge clk); gate = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; gate = 1'b0; ctl_wr = 1'b0; ctl_mode = 3'd0; ctl_bcd = 1'b0;
    ld_wr = 1'b0; ld_val = '0; ld_num = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    vectors++;
    if (out !== 1'b1 || count !== '0 || null_count !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b/%h/%0b expected=1/0000/0", out, count, null_count);
    end
    chk_on = 1;

    // R2 terminal count with R11 gate hold
    do_ctl(0, 0); do_ld(10); gate_set(1); idle(4);
    gate_set(0); idle(3); gate_set(1); idle(12);
    do_ld(3); idle(6);

    // R3 one-shot: new count mid-pulse, then retrigger
    do_ctl(1, 0); do_ld(5); idle(2);
    gate_set(0); gate_set(1); idle(8);
    gate_set(0); gate_set(1); idle(1); do_ld(8); idle(8);
    gate_set(0); gate_set(1); idle(2); gate_set(0); gate_set(1); idle(12);

    // R4 rate generator, gate suspend, deferred new count
    do_ctl(2, 0); do_ld(4); idle(14);
    gate_set(0); idle(3); gate_set(1); idle(9);
    do_ld(6); idle(16);

    // R5 square wave, odd then even
    do_ctl(3, 0); do_ld(7); idle(22);
    do_ld(6); idle(20);
    gate_set(0); idle(3); gate_set(1); idle(10);

    // R10 alias codes
    do_ctl(6, 0); do_ld(3); idle(10);
    do_ctl(7, 0); do_ld(5); idle(12);

    // R6 software strobe, then R8 full binary range
    do_ctl(4, 0); do_ld(5); idle(10);
    do_ld(0); idle(65545);

    // R7 gate strobe with retrigger
    do_ctl(5, 0); do_ld(4); gate_set(0); gate_set(1); idle(8);
    gate_set(0); gate_set(1); idle(2); gate_set(0); gate_set(1); idle(8);

    // R8 BCD counting in several modes, full BCD range
    do_ctl(2, 1); do_ld(12); idle(30);
    do_ctl(3, 1); do_ld(15); idle(35);
    do_ctl(0, 1); do_ld(25); idle(30);
    do_ctl(4, 1); do_ld(0); idle(10010);

    finish_run();
  end

endmodule